// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operand Forms

This block is the integer execute stage of a 32-bit RISC core. Each issued operation carries two register operands, a 16-bit immediate, a 5-bit shift immediate, a destination register number and an operation code. The unit produces a 32-bit result with a register-file write enable. It covers add and subtract, the bitwise operations, shifts and rotates, set-on-compare, low-half and high-half multiply, and signed and unsigned divide. The divide corner cases have defined results.

All operations except division finish in one cycle. Division runs on a 32-step restoring divider. While it works, the unit raises `busy`, and any issue offered in that time is dropped. The surrounding pipeline stalls on `busy`. It takes the result when `res_valid` is high and writes the register file when `res_we` is high.

Top module: `int_exec_unit`

## Requirements
- R1: A register-register add, subtract, AND, OR, XOR or NOR issued while `busy` is low gives `res_valid` high with its result in the cycle after the issuing clock edge, for exactly one cycle. The destination appears on `res_dest` in the same cycle.
- R2: The add-immediate and multiply-immediate forms sign-extend `imm16` to 32 bits. The AND, OR and XOR immediate forms zero-extend it. `src_b` is ignored by every immediate form.
- R3: The high-half AND, OR and XOR immediate forms use `imm16` placed in bits 31:16 with zeros in bits 15:0 as the second operand.
- R4: Register-amount shifts and rotates (left logical, right logical, right arithmetic, rotate left, rotate right) take their amount from `src_b[4:0]` only. The immediate shift and rotate-left forms take it from `imm5`.
- R5: Compare operations return 1 or 0 for greater-or-equal, less-than, not-equal and equal, in signed and unsigned forms. Immediate signed, equal and not-equal compares sign-extend `imm16`. Immediate unsigned compares zero-extend it.
- R6: Plain multiply returns the low 32 bits of the product. The three high multiplies return bits 63:32 of the 64-bit product for signed×signed, unsigned×unsigned and signed(`src_a`)×unsigned(`src_b`) operands.
- R7: Signed divide truncates toward zero. A zero divisor, or a dividend of 0x80000000 with a divisor of 0xFFFFFFFF, returns the dividend.
- R8: Unsigned divide returns the unsigned quotient, and returns the dividend when the divisor is zero.
- R9: A divide accepted at edge E0 raises `busy` from the cycle after E0. Its result appears with `res_valid` high in the cycle after edge E32. `busy` stays high through that result cycle and is low in the cycle after it.
- R10: An issue offered while `busy` is high is ignored. It produces no result and does not disturb the divide in flight. This includes an issue offered in the divide's result cycle.
- R11: `res_we` equals `res_valid` when `res_dest` is non-zero, and is low when `res_dest` is 0.
- R12: While `rst` is high, `busy`, `res_valid` and `res_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_op | input | 6 | Operation code (package enumeration) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | 16-bit immediate field |
| imm5 | input | 5 | Immediate shift amount |
| dest | input | 5 | Destination register number |
| busy | output | 1 | Divider occupied; new issues are ignored |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 32 | Result value |
| res_dest | output | 5 | Destination register of the result |
| res_we | output | 1 | Register-file write enable |

## Verification
Two functions can meet in one cycle: the divider presenting its result, and a new single-cycle operation being offered in that same cycle. The bench provokes this on every divide. It holds an add issue asserted from the cycle after the divide is accepted through the divide's result cycle, with operands unrelated to the divide. It judges the outcome in three ways. The result cycle must carry the divide's quotient and destination. No result may appear in any cycle before it. The cycle after it must show neither `res_valid` nor `busy`, which proves that the overlapping issue was dropped rather than queued or merged.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int SH_W   = $clog2(XLEN);
    localparam int REG_AW = 5;
    localparam int OP_W   = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_ADDI, OP_ANDI, OP_ORI, OP_XORI, OP_ANDHI, OP_ORHI, OP_XORHI,
        OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
        OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI,
        OP_CMPGE, OP_CMPLT, OP_CMPNE, OP_CMPEQ, OP_CMPGEU, OP_CMPLTU,
        OP_CMPGEI, OP_CMPLTI, OP_CMPNEI, OP_CMPEQI, OP_CMPGEUI, OP_CMPLTUI,
        OP_MUL, OP_MULI, OP_MULHSS, OP_MULHUU, OP_MULHSU,
        OP_DIV, OP_DIVU
    } exu_op_e;

    typedef enum logic [1:0] {U_ARITH, U_SHIFT, U_MUL, U_DIV} exu_unit_e;

    typedef enum logic [1:0] {IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_HIGH} imm_kind_e;

    typedef struct packed {
        exu_unit_e unit;
        imm_kind_e imm;
        logic      use_imm5;
    } exu_ctl_t;

    function automatic exu_ctl_t exu_decode(exu_op_e op);
        exu_ctl_t c;
        c = '{unit: U_ARITH, imm: IMM_NONE, use_imm5: 1'b0};
        case (op)
            OP_ADDI, OP_CMPGEI, OP_CMPLTI, OP_CMPNEI, OP_CMPEQI:
                c.imm = IMM_SEXT;
            OP_ANDI, OP_ORI, OP_XORI, OP_CMPGEUI, OP_CMPLTUI:
                c.imm = IMM_ZEXT;
            OP_ANDHI, OP_ORHI, OP_XORHI:
                c.imm = IMM_HIGH;
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR:
                c.unit = U_SHIFT;
            OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI: begin
                c.unit     = U_SHIFT;
                c.use_imm5 = 1'b1;
            end
            OP_MULI: begin
                c.unit = U_MUL;
                c.imm  = IMM_SEXT;
            end
            OP_MUL, OP_MULHSS, OP_MULHUU, OP_MULHSU:
                c.unit = U_MUL;
            OP_DIV, OP_DIVU:
                c.unit = U_DIV;
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic [XLEN-1:0] exu_imm_value(imm_kind_e k, logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] v;
        case (k)
            IMM_SEXT: v = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
            IMM_ZEXT: v = {{(XLEN-IMM_W){1'b0}}, imm};
            IMM_HIGH: v = {imm, {(XLEN-IMM_W){1'b0}}};
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/exu_arith.sv
module exu_arith
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  exu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);

    logic lt_s, lt_u, eq;
    logic [W-1:0] flag_one;

    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;
    assign eq   = (a == b);
    assign flag_one = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        case (op)
            OP_ADD, OP_ADDI:                res = a + b;
            OP_SUB:                         res = a - b;
            OP_AND, OP_ANDI, OP_ANDHI:      res = a & b;
            OP_OR,  OP_ORI,  OP_ORHI:       res = a | b;
            OP_XOR, OP_XORI, OP_XORHI:      res = a ^ b;
            OP_NOR:                         res = ~(a | b);
            OP_CMPGE,  OP_CMPGEI:           res = lt_s ? '0 : flag_one;
            OP_CMPLT,  OP_CMPLTI:           res = lt_s ? flag_one : '0;
            OP_CMPGEU, OP_CMPGEUI:          res = lt_u ? '0 : flag_one;
            OP_CMPLTU, OP_CMPLTUI:          res = lt_u ? flag_one : '0;
            OP_CMPEQ,  OP_CMPEQI:           res = eq ? flag_one : '0;
            OP_CMPNE,  OP_CMPNEI:           res = eq ? '0 : flag_one;
            default:                        res = '0;
        endcase
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  exu_op_e        op,
    input  logic [W-1:0]   val,
    input  logic [AW-1:0]  amt,
    output logic [W-1:0]   res
);

    logic go_left, rotate, arith;
    logic [W-1:0] val_rev, in_lo, hi_fill, out_lo, out_rev;

    always_comb begin
        go_left = 1'b0;
        rotate  = 1'b0;
        arith   = 1'b0;
        case (op)
            OP_SLL, OP_SLLI: go_left = 1'b1;
            OP_ROL, OP_ROLI: begin
                go_left = 1'b1;
                rotate  = 1'b1;
            end
            OP_ROR:          rotate  = 1'b1;
            OP_SRA, OP_SRAI: arith   = 1'b1;
            default: ;
        endcase
    end

    // Left moves are done as right moves on the bit-reversed word.
    for (genvar g = 0; g < W; g++) begin : g_rev
        assign val_rev[g] = val[W-1-g];
        assign out_rev[g] = out_lo[W-1-g];
    end

    assign in_lo   = go_left ? val_rev : val;
    assign hi_fill = rotate ? in_lo : (arith ? {W{val[W-1]}} : '0);
    assign out_lo  = W'({hi_fill, in_lo} >> amt);
    assign res     = go_left ? out_rev : out_lo;

endmodule

// File: rtl/exu_multiplier.sv
module exu_multiplier #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_signed,
    input  logic         b_signed,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);

    localparam int PW = 2 * W + 2;

    logic [PW-1:0] ea, eb;

    // Operands extended to full product width; the modular product is exact.
    assign ea = {{(PW-W){a_signed & a[W-1]}}, a};
    assign eb = {{(PW-W){b_signed & b[W-1]}}, b};

    assign lo = W'(ea * eb);
    assign hi = W'((ea * eb) >> W);

endmodule

// File: rtl/exu_divider.sv
module exu_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         run,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CNT_W = $clog2(W);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic             corner, neg_a, neg_b;
    logic [W-1:0]     dvs_fix, mag_a, mag_b;
    logic [W-1:0]     rem_q, quo_q, dvs_q;
    logic             neg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       trial;
    logic             corner_q;
    logic [W-1:0]     dvd_q;

    assign corner  = (divisor == '0) ||
                     (is_signed && dividend == MIN_NEG && divisor == '1);
    assign dvs_fix = corner ? W'(1) : divisor;
    assign neg_a   = is_signed & dividend[W-1];
    assign neg_b   = is_signed & dvs_fix[W-1];
    assign mag_a   = neg_a ? -dividend : dividend;
    assign mag_b   = neg_b ? -dvs_fix : dvs_fix;

    assign trial   = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            done     <= 1'b0;
            rem_q    <= '0;
            quo_q    <= '0;
            dvs_q    <= '0;
            neg_q    <= 1'b0;
            cnt_q    <= '0;
            corner_q <= 1'b0;
            dvd_q    <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run      <= 1'b1;
                rem_q    <= '0;
                quo_q    <= mag_a;
                dvs_q    <= mag_b;
                neg_q    <= neg_a ^ neg_b;
                cnt_q    <= '0;
                corner_q <= corner;
                dvd_q    <= dividend;
            end else if (run) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(W - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = neg_q ? -quo_q : quo_q;

    // R9: a finished pulse is only produced at the end of a run.
    p_done_after_run_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(run));

    // R9: an accepted start always begins an iteration sequence.
    p_start_runs_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> run);

    // R7/R8: a corner-case divide hands back the original dividend.
    p_corner_dividend_r7: assert property (@(posedge clk) disable iff (rst)
        (done && corner_q) |-> (quotient == dvd_q));

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [SH_W-1:0]   imm5,
    input  logic [REG_AW-1:0] dest,
    output logic              busy,
    output logic              res_valid,
    output logic [XLEN-1:0]   res_data,
    output logic [REG_AW-1:0] res_dest,
    output logic              res_we
);

    exu_op_e          op_e;
    exu_ctl_t         ctl;
    logic             accept;
    logic [XLEN-1:0]  opnd_b;
    logic [SH_W-1:0]  sh_amt;
    logic [XLEN-1:0]  arith_res, shift_res, mul_lo, mul_hi, unit_res;
    logic             mul_a_sgn, mul_b_sgn, mul_want_hi;
    logic             div_run, div_done;
    logic [XLEN-1:0]  div_quo;

    logic              alu_v_q;
    logic [XLEN-1:0]   alu_data_q;
    logic [REG_AW-1:0] alu_dest_q, div_dest_q;

    assign op_e   = exu_op_e'(issue_op);
    assign ctl    = exu_decode(op_e);
    assign busy   = div_run | div_done;
    assign accept = issue_valid && !busy;
    assign opnd_b = (ctl.imm == IMM_NONE) ? src_b : exu_imm_value(ctl.imm, imm16);
    assign sh_amt = ctl.use_imm5 ? imm5 : src_b[SH_W-1:0];

    exu_arith #(.W(XLEN)) u_arith (
        .op  (op_e),
        .a   (src_a),
        .b   (opnd_b),
        .res (arith_res)
    );

    exu_shifter #(.W(XLEN), .AW(SH_W)) u_shift (
        .op  (op_e),
        .val (src_a),
        .amt (sh_amt),
        .res (shift_res)
    );

    assign mul_a_sgn   = (op_e == OP_MULHSS) || (op_e == OP_MULHSU);
    assign mul_b_sgn   = (op_e == OP_MULHSS);
    assign mul_want_hi = (op_e == OP_MULHSS) || (op_e == OP_MULHUU) || (op_e == OP_MULHSU);

    exu_multiplier #(.W(XLEN)) u_mul (
        .a        (src_a),
        .b        (opnd_b),
        .a_signed (mul_a_sgn),
        .b_signed (mul_b_sgn),
        .lo       (mul_lo),
        .hi       (mul_hi)
    );

    exu_divider #(.W(XLEN)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && ctl.unit == U_DIV),
        .is_signed (op_e == OP_DIV),
        .dividend  (src_a),
        .divisor   (opnd_b),
        .run       (div_run),
        .done      (div_done),
        .quotient  (div_quo)
    );

    always_comb begin
        case (ctl.unit)
            U_SHIFT: unit_res = shift_res;
            U_MUL:   unit_res = mul_want_hi ? mul_hi : mul_lo;
            default: unit_res = arith_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_v_q    <= 1'b0;
            alu_data_q <= '0;
            alu_dest_q <= '0;
            div_dest_q <= '0;
        end else begin
            alu_v_q <= accept && (ctl.unit != U_DIV);
            if (accept && ctl.unit != U_DIV) begin
                alu_data_q <= unit_res;
                alu_dest_q <= dest;
            end
            if (accept && ctl.unit == U_DIV) begin
                div_dest_q <= dest;
            end
        end
    end

    assign res_valid = alu_v_q | div_done;
    assign res_data  = div_done ? div_quo : alu_data_q;
    assign res_dest  = div_done ? div_dest_q : alu_dest_q;
    assign res_we    = res_valid && (res_dest != '0);

    // R10: nothing offered during a busy cycle turns into a single-cycle result.
    p_no_issue_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !alu_v_q);

    // R10: the divider and the single-cycle path never report in the same cycle.
    p_one_source_r10: assert property (@(posedge clk) disable iff (rst)
        !(alu_v_q && div_done));

    // R11: a result aimed at register 0 is never written.
    p_no_write_r0_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_dest == '0) |-> !res_we);

    // R9: busy holds for the whole divide, including the result cycle.
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        div_run |=> busy);

endmodule

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/100ps
module int_exec_unit_tb_top;
    import exu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [5:0]  issue_op = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  imm5 = '0;
    logic [4:0]  dest = '0;
    logic        busy, res_valid, res_we;
    logic [31:0] res_data;
    logic [4:0]  res_dest;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .src_a(src_a), .src_b(src_b), .imm16(imm16), .imm5(imm5), .dest(dest),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_dest(res_dest), .res_we(res_we)
    );

    function automatic logic [31:0] val(int k);
        case (k)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0001;
            2:  return 32'h0000_0007;
            3:  return 32'h0000_0021;
            4:  return 32'hFFFF_FFFF;
            5:  return 32'hFFFF_FFF9;
            6:  return 32'h8000_0000;
            7:  return 32'h7FFF_FFFF;
            8:  return 32'h1234_5678;
            9:  return 32'hDEAD_BEEF;
            10: return 32'h0001_8000;
            default: return 32'hFFFF_0003;
        endcase
    endfunction

    function automatic logic [31:0] rotl(logic [31:0] x, int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] ref_result(exu_op_e op, logic [31:0] a, logic [31:0] b,
                                               logic [15:0] i16, logic [4:0] i5);
        int ia, ib;
        longint pa, pb, ps;
        longint unsigned ua, ub, pu;
        logic [31:0] sx, zx, hx;
        int n;
        ia = a; ib = b;
        sx = {{16{i16[15]}}, i16};
        zx = {16'h0000, i16};
        hx = {i16, 16'h0000};
        n  = int'(b[4:0]);
        case (op)
            OP_ADD:    return a + b;
            OP_SUB:    return a - b;
            OP_AND:    return a & b;
            OP_OR:     return a | b;
            OP_XOR:    return a ^ b;
            OP_NOR:    return ~(a | b);
            OP_ADDI:   return a + sx;
            OP_ANDI:   return a & zx;
            OP_ORI:    return a | zx;
            OP_XORI:   return a ^ zx;
            OP_ANDHI:  return a & hx;
            OP_ORHI:   return a | hx;
            OP_XORHI:  return a ^ hx;
            OP_SLL:    return a << n;
            OP_SRL:    return a >> n;
            OP_SRA:    return $unsigned(ia >>> n);
            OP_ROL:    return rotl(a, n);
            OP_ROR:    return rotl(a, (32 - n) % 32);
            OP_SLLI:   return a << i5;
            OP_SRLI:   return a >> i5;
            OP_SRAI:   return $unsigned(ia >>> i5);
            OP_ROLI:   return rotl(a, int'(i5));
            OP_CMPGE:  return (ia >= ib) ? 1 : 0;
            OP_CMPLT:  return (ia < ib) ? 1 : 0;
            OP_CMPNE:  return (a != b) ? 1 : 0;
            OP_CMPEQ:  return (a == b) ? 1 : 0;
            OP_CMPGEU: return (a >= b) ? 1 : 0;
            OP_CMPLTU: return (a < b) ? 1 : 0;
            OP_CMPGEI: return (ia >= int'(sx)) ? 1 : 0;
            OP_CMPLTI: return (ia < int'(sx)) ? 1 : 0;
            OP_CMPNEI: return (a != sx) ? 1 : 0;
            OP_CMPEQI: return (a == sx) ? 1 : 0;
            OP_CMPGEUI: return (a >= zx) ? 1 : 0;
            OP_CMPLTUI: return (a < zx) ? 1 : 0;
            OP_MUL:    return a * b;
            OP_MULI:   return a * sx;
            OP_MULHSS: begin pa = ia; pb = ib; ps = pa * pb; return ps[63:32]; end
            OP_MULHUU: begin ua = a; ub = b; pu = ua * ub; return pu[63:32]; end
            OP_MULHSU: begin pa = ia; pb = longint'(b); ps = pa * pb; return ps[63:32]; end
            OP_DIV: begin
                if (b == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) return a;
                return $unsigned(ia / ib);
            end
            OP_DIVU: begin
                if (b == 0) return a;
                return a / b;
            end
            default:   return 32'h0;
        endcase
    endfunction

    function automatic string req_of(exu_op_e op);
        case (op)
            OP_ADDI, OP_ANDI, OP_ORI, OP_XORI, OP_MULI: return "R2";
            OP_ANDHI, OP_ORHI, OP_XORHI: return "R3";
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
            OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI: return "R4";
            OP_CMPGE, OP_CMPLT, OP_CMPNE, OP_CMPEQ, OP_CMPGEU, OP_CMPLTU,
            OP_CMPGEI, OP_CMPLTI, OP_CMPNEI, OP_CMPEQI, OP_CMPGEUI, OP_CMPLTUI: return "R5";
            OP_MUL, OP_MULHSS, OP_MULHUU, OP_MULHSU: return "R6";
            OP_DIV: return "R7";
            OP_DIVU: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // One divide with an ALU issue held across its whole run (R9, R10).
    task automatic run_div(exu_op_e op, int i, int j);
        logic [31:0] a, b, exp;
        logic [4:0]  d;
        bit leak;
        a = val(i); b = val(j);
        d = 5'(i + 2 * j);
        exp = ref_result(op, a, b, 16'h0, 5'h0);
        issue_valid = 1'b1; issue_op = op; src_a = a; src_b = b; dest = d;
        @(negedge clk);
        chk("R9", "busy after divide issue", 32'(busy), 32'd1);
        issue_op = OP_ADD; src_a = 32'h0000_1111; src_b = 32'h0000_2222; dest = 5'd9;
        leak = 1'b0;
        if (res_valid) leak = 1'b1;
        repeat (31) begin
            @(negedge clk);
            if (res_valid || !busy) leak = 1'b1;
        end
        @(negedge clk);
        chk("R10", "early result or dropped busy", 32'(leak), 32'd0);
        chk("R9", "divide result valid", 32'(res_valid), 32'd1);
        chk("R9", "busy in result cycle", 32'(busy), 32'd1);
        chk(req_of(op), $sformatf("%s %h/%h", op.name(), a, b), res_data, exp);
        chk("R11", "divide write enable", 32'(res_we), 32'(d != 0));
        chk("R9", "divide destination", 32'(res_dest), 32'(d));
        @(negedge clk);
        chk("R10", "issue in result cycle ignored", 32'(res_valid), 32'd0);
        chk("R9", "busy low after result", 32'(busy), 32'd0);
        issue_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        exu_op_e o;
        logic [31:0] a, b, exp;
        logic [4:0] d;
        repeat (3) @(negedge clk);
        chk("R12", "busy in reset", 32'(busy), 32'd0);
        chk("R12", "res_valid in reset", 32'(res_valid), 32'd0);
        chk("R12", "res_we in reset", 32'(res_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle no result", 32'(res_valid), 32'd0);

        // Sweep every single-cycle operation over operand pairs.
        o = o.first();
        do begin
            if (o != OP_DIV && o != OP_DIVU) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++) begin
                        a = val(i); b = val(j);
                        d = 5'(3 * i + j);
                        issue_valid = 1'b1; issue_op = o; src_a = a; src_b = b;
                        imm16 = b[15:0] ^ 16'h00A5; imm5 = b[9:5]; dest = d;
                        exp = ref_result(o, a, b, imm16, imm5);
                        @(negedge clk);
                        chk("R1", "single-cycle valid", 32'(res_valid), 32'd1);
                        chk(req_of(o), $sformatf("%s %h,%h imm %h/%h", o.name(), a, b, imm16, imm5),
                            res_data, exp);
                        chk("R11", "write enable vs dest", 32'(res_we), 32'(d != 0));
                        chk("R1", "destination", 32'(res_dest), 32'(d));
                    end
                end
            end
            o = o.next();
        end while (o != o.first());
        issue_valid = 1'b0;
        @(negedge clk);
        chk("R1", "result lasts one cycle", 32'(res_valid), 32'd0);

        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                run_div(OP_DIV, i, j);
                run_div(OP_DIVU, i, j);
            end
        end

        @(negedge clk);
        chk("R10", "quiet after divides", 32'(res_valid), 32'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule